// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

This block watches a vector of level-sensitive maskable interrupt requests plus one non-maskable request, and reports the single source that should be serviced next. It outputs that source's vector number and byte address, with a valid flag. The consumer takes the result by raising an acknowledge.

Each maskable source belongs to a group, and each group has one bit in a control-level register. When a group's bit is set, all of its sources are promoted ahead of every source in an unpromoted group. Inside either level, the fixed order by ascending vector number decides. The non-maskable request is edge-captured into a pending flag and beats every maskable source. A global mask input blocks all maskable sources and never blocks the non-maskable one.

Top module: `irq_level_arbiter`

## Requirements
- R1: Maskable source i carries vector VEC_BASE+i (16+i by default). Among pending sources at the same control level, the lowest vector number wins.
- R2: A source whose group bit in the control-level register is 1 beats every source whose group bit is 0. The group of each source comes from the GRP_MAP parameter (default: source 0 to bit 7, source 1 to bit 6, sources 2-3 to bit 5, 4-5 to bit 4, 6-7 to bit 3, 8-9 to bit 2, 10-11 to bit 1, 12-15 to bit 0).
- R3: The vector address output equals the vector number times four, zero-extended to the address width.
- R4: A rising edge on nmi_in sets a pending flag. While that flag is set, the output presents vector 7 (address 0x00001C) over any maskable source, including promoted ones.
- R5: The pending non-maskable flag clears when ack is high while vector 7 is presented with valid. A level held high after that does not set it again until a new rising edge.
- R6: When mask_all is high, no maskable source is reported. A pending non-maskable request is still reported.
- R7: req_valid, vec_num and vec_addr are registered and reflect the inputs one clock after they change. While req_valid is high and ack is low, they hold their value.
- R8: When nothing is pending, req_valid, vec_num and vec_addr are all zero after the next clock. All three are zero out of reset.
- R9: A clock edge with cfg_we high loads cfg_wdata into the control-level register, which reads back on cfg_rdata. The register resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_SRC | Level-sensitive maskable requests, bit i is vector VEC_BASE+i |
| nmi_in | input | 1 | Non-maskable request, rising-edge captured |
| mask_all | input | 1 | Blocks every maskable request |
| cfg_we | input | 1 | Write strobe for the control-level register |
| cfg_wdata | input | NUM_GRP | Write data for the control-level register |
| cfg_rdata | output | NUM_GRP | Current control-level register |
| ack | input | 1 | Consumer accepts the presented vector |
| req_valid | output | 1 | A source is being presented |
| vec_num | output | VW | Winning vector number, zero when idle |
| vec_addr | output | AW | Winning vector address |

## Verification
The bench builds the arbiter with NUM_SRC=8 and NUM_GRP=4. The map is source 0 to bit 3, source 1 to bit 2, sources 2-3 to bit 1, and sources 4-7 to bit 0. This reduced shape keeps single-source groups, paired groups and a four-source group, and it makes every combination of request pattern, control-level value and global mask small enough to sweep exhaustively (8192 cases). Each case is compared against an arithmetic model of the two-level order. Directed sequences then cover output hold without acknowledge, non-maskable capture, clearing, and re-arming on a fresh edge.

// File: rtl/irq_arb_pkg.sv
// Shared types and helpers for the two-level interrupt arbiter.
// Assumes vector numbers fit in 8 bits.
package irq_arb_pkg;

    typedef struct packed {
        logic       valid;
        logic [7:0] vec;
    } pick_t;

endpackage

// File: rtl/irq_nmi_latch.sv
// Captures rising edges of the non-maskable request into a pending flag.
// Assumes nmi_in is already synchronous to clk. pend_next gives the flag's
// next value, so the selector can act on a clear in the same cycle.
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic clr,
    output logic pend,
    output logic pend_next
);
    logic nmi_q;
    logic rise;

    // Edge detect and next-state of the pending flag; a new edge wins over a clear.
    always_comb begin
        rise      = nmi_in & ~nmi_q;
        pend_next = rise | (pend & ~clr);
    end

    // Register the previous level and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            pend  <= pend_next;
        end
    end

    // R4: a rising edge always leaves the flag set.
    assert_nmi_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_in && !nmi_q) |=> pend);

    // R5: without a clear the flag stays set.
    assert_nmi_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

endmodule

// File: rtl/irq_level_select.sv
// Combinational two-level priority selection. A source is promoted when the
// control-level bit of its group is set; the lowest-index promoted source wins,
// otherwise the lowest-index eligible one. A pending NMI overrides everything.
// Assumes NUM_GRP >= 2 and every GRP_MAP entry < NUM_GRP.
module irq_level_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_GRP  = 8,
    parameter int GW       = $clog2(NUM_GRP),
    parameter logic [NUM_SRC*GW-1:0] GRP_MAP = '0,
    parameter int VEC_BASE = 16,
    parameter int NMI_VEC  = 7
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_GRP-1:0] ctl,
    input  logic               mask_all,
    input  logic               nmi_pend,
    output pick_t              pick
);
    logic [NUM_SRC-1:0] promo;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] hi;

    // Per-source promotion bit taken from its group's control level.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_promo
        assign promo[i] = ctl[GRP_MAP[i*GW +: GW]];
    end

    // Eligible and promoted request sets.
    always_comb begin
        elig = req & {NUM_SRC{~mask_all}};
        hi   = elig & promo;
    end

    // Pick the winner: NMI, then lowest promoted, then lowest eligible.
    always_comb begin
        logic [7:0] lo_vec;
        logic [7:0] hi_vec;
        lo_vec = '0;
        hi_vec = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) lo_vec = 8'(VEC_BASE + i);
            if (hi[i])   hi_vec = 8'(VEC_BASE + i);
        end
        if (nmi_pend) begin
            pick.valid = 1'b1;
            pick.vec   = 8'(NMI_VEC);
        end else if (|hi) begin
            pick.valid = 1'b1;
            pick.vec   = hi_vec;
        end else if (|elig) begin
            pick.valid = 1'b1;
            pick.vec   = lo_vec;
        end else begin
            pick.valid = 1'b0;
            pick.vec   = '0;
        end
    end

endmodule

// File: rtl/irq_level_arbiter.sv
// Top of the two-level interrupt arbiter: holds the control-level register,
// the NMI pending latch and the registered output. The output reloads every
// clock unless a valid result is waiting for acknowledge.
// Assumes requests are synchronous and a source drops its line once acknowledged.
module irq_level_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_GRP  = 8,
    parameter logic [NUM_SRC*$clog2(NUM_GRP)-1:0] GRP_MAP =
        {3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2,
         3'd3, 3'd3, 3'd4, 3'd4, 3'd5, 3'd5, 3'd6, 3'd7},
    parameter int VEC_BASE = 16,
    parameter int NMI_VEC  = 7,
    parameter int VW       = 8,
    parameter int AW       = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               nmi_in,
    input  logic               mask_all,
    input  logic               cfg_we,
    input  logic [NUM_GRP-1:0] cfg_wdata,
    output logic [NUM_GRP-1:0] cfg_rdata,
    input  logic               ack,
    output logic               req_valid,
    output logic [VW-1:0]      vec_num,
    output logic [AW-1:0]      vec_addr
);
    localparam int GW = $clog2(NUM_GRP);

    logic [NUM_GRP-1:0] ctl_q;
    logic               nmi_pend;
    logic               nmi_pend_next;
    logic               nmi_clr;
    logic               hold;
    pick_t              pick;

    // Acknowledge handling: hold while waiting, clear NMI when its vector is taken.
    always_comb begin
        hold    = req_valid & ~ack;
        nmi_clr = ack & req_valid & (vec_num == VW'(NMI_VEC));
    end

    // Control-level register write port.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (cfg_we) ctl_q <= cfg_wdata;
    end
    assign cfg_rdata = ctl_q;

    irq_nmi_latch u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_in    (nmi_in),
        .clr       (nmi_clr),
        .pend      (nmi_pend),
        .pend_next (nmi_pend_next)
    );

    irq_level_select #(
        .NUM_SRC  (NUM_SRC),
        .NUM_GRP  (NUM_GRP),
        .GW       (GW),
        .GRP_MAP  (GRP_MAP),
        .VEC_BASE (VEC_BASE),
        .NMI_VEC  (NMI_VEC)
    ) u_sel (
        .req      (irq_req),
        .ctl      (ctl_q),
        .mask_all (mask_all),
        .nmi_pend (nmi_pend_next),
        .pick     (pick)
    );

    // Output register: reload unless a presented result awaits acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            vec_num   <= '0;
            vec_addr  <= '0;
        end else if (!hold) begin
            req_valid <= pick.valid;
            vec_num   <= VW'(pick.vec);
            vec_addr  <= AW'({pick.vec, 2'b00});
        end
    end

    // R7: an unacknowledged result stays put.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ack) |=> (req_valid && $stable(vec_num) && $stable(vec_addr)));

    // R8: idle output carries no vector.
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (vec_num == '0 && vec_addr == '0));

    // R6: with the mask set and no NMI, nothing is reported next.
    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_all && !nmi_pend_next && !hold) |=> !req_valid);

    // R4: a pending NMI on reload is what gets presented.
    assert_nmi_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend_next && !hold) |=> (vec_num == VW'(NMI_VEC)));

    // R3: address tracks the vector number.
    assert_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (vec_addr == AW'(vec_num) * 4));

endmodule

// File: tb/sim_irq_level_arbiter.sv
module sim_irq_level_arbiter;
    localparam int NS = 8;
    localparam int NG = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic          nmi_in = 1'b0;
    logic          mask_all = 1'b0;
    logic          cfg_we = 1'b0;
    logic [NG-1:0] cfg_wdata = '0;
    logic [NG-1:0] cfg_rdata;
    logic          ack = 1'b0;
    logic          req_valid;
    logic [7:0]    vec_num;
    logic [23:0]   vec_addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_level_arbiter #(
        .NUM_SRC (NS),
        .NUM_GRP (NG),
        .GRP_MAP (16'h005B)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .irq_req (irq_req), .nmi_in (nmi_in),
        .mask_all (mask_all), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata), .ack (ack), .req_valid (req_valid),
        .vec_num (vec_num), .vec_addr (vec_addr)
    );

    // Group of source i in the bench configuration (R2).
    function automatic int grp_of(int i);
        if (i == 0) return 3;
        if (i == 1) return 2;
        if (i < 4)  return 1;
        return 0;
    endfunction

    // Expected vector from the two-level order; 0 means idle.
    function automatic int model(logic [NS-1:0] r, logic [NG-1:0] c, logic m);
        int best_hi = -1;
        int best_lo = -1;
        if (m) return 0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (r[i]) begin
                best_lo = i;
                if (c[grp_of(i)]) best_hi = i;
            end
        end
        if (best_hi >= 0) return 16 + best_hi;
        if (best_lo >= 0) return 16 + best_lo;
        return 0;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_out(string tag, int exp);
        check(req_valid == (exp != 0), tag, int'(req_valid), int'(exp != 0));
        check(vec_num == 8'(exp), tag, int'(vec_num), exp);
        check(vec_addr == 24'(exp * 4), {tag, " R3 addr"}, int'(vec_addr), exp * 4);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R8 reset", 0);
        check(cfg_rdata == '0, "R9 reset cfg", int'(cfg_rdata), 0);
        rst_n = 1'b1;

        // Exhaustive sweep, R1 R2 R6 R9: ack held so the output reloads each cycle.
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 16; c++) begin
                for (int r = 0; r < 256; r++) begin
                    cfg_we    = 1'b1;
                    cfg_wdata = NG'(c);
                    irq_req   = NS'(r);
                    mask_all  = m[0];
                    ack       = 1'b1;
                    @(posedge clk);
                    @(negedge clk);
                    cfg_we = 1'b0;
                    @(posedge clk);
                    @(negedge clk);
                    check(cfg_rdata == NG'(c), "R9 readback", int'(cfg_rdata), c);
                    check_out("R1 R2 R6 sweep", model(NS'(r), NG'(c), m[0]));
                end
            end
        end

        // Idle and hold behaviour, R7 R8.
        irq_req = '0; mask_all = 1'b0; cfg_wdata = '0; cfg_we = 1'b1; ack = 1'b0;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        @(posedge clk); @(negedge clk);
        check_out("R8 idle", 0);
        irq_req = 8'h08;
        @(posedge clk); @(negedge clk);
        check_out("R7 one cycle", 19);
        irq_req = 8'h09;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R7 hold", 19);
        ack = 1'b1; irq_req = 8'h01;
        @(posedge clk); @(negedge clk);
        ack = 1'b0;
        check_out("R7 after ack", 16);
        irq_req = '0; ack = 1'b1;
        @(posedge clk); @(negedge clk);
        ack = 1'b0;
        check_out("R8 back to idle", 0);

        // NMI capture, priority and clearing, R4 R5 R6.
        mask_all = 1'b1; irq_req = 8'hFF; cfg_wdata = 4'hF; cfg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
        check_out("R6 masked", 0);
        nmi_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check_out("R4 nmi", 7);
        ack = 1'b1;
        @(posedge clk); @(negedge clk);
        ack = 1'b0;
        check_out("R5 nmi cleared", 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R5 no retrigger", 0);
        nmi_in = 1'b0;
        @(posedge clk); @(negedge clk);
        nmi_in = 1'b1; mask_all = 1'b0;
        @(posedge clk); @(negedge clk);
        check_out("R4 nmi over promoted", 7);
        ack = 1'b1; irq_req = 8'h30;
        @(posedge clk); @(negedge clk);
        ack = 1'b0;
        check_out("R5 next after nmi", 20);

        finish_run();
    end
endmodule